// File: doc/BRIEF.md
# Capture/Compare Channel

This block is a single channel that watches a free-running 16-bit counter supplied from outside. A 7-bit mode word selects what the channel does with its 16-bit capture/compare register. It can latch the counter on a chosen edge of an input pin, set an event flag when the counter equals the register, toggle an output pin on each such equality, or produce an 8-bit pulse-width-modulated waveform.

In PWM operation only the low byte of the counter is compared, against the low byte of the register. The high byte holds the next duty value, which is copied into the low byte whenever the counter's low byte rolls over. This lets software change the duty cycle without a glitch.

A sticky event flag collects captures and matches. It drives a per-channel interrupt request gated by the mode word's enable bit, and a shared request gated by an enable from outside. Several channels can sit on one counter, each with its own instance.

Top module: `cc_channel`

## Requirements
- R1: After reset the mode word and the capture/compare register read 0, the output pin reads 1, and the flag and both requests read 0. The mode word bits are: bit 6 compare enable, bit 5 rising-edge capture, bit 4 falling-edge capture, bit 3 match, bit 2 toggle, bit 1 PWM and bit 0 interrupt enable. A written mode word reads back unchanged.
- R2: With bit 5 set, a rising edge on `pin_in` copies `cnt_val` into the register at the third rising clock edge after the pin changes, and sets the flag.
- R3: With only bit 4 set, a falling edge captures and sets the flag. A rising edge then changes neither the register nor the flag.
- R4: With bits 5 and 4 both set, edges of either direction capture.
- R5: With bits 6 and 3 set, a cycle with `cnt_tick` high and `cnt_val` equal to the register sets the flag at the next clock edge. An equal value without `cnt_tick` sets nothing.
- R6: With bits 6, 3 and 2 set, each match inverts `pin_out` at the next clock edge. A tick that does not match leaves the pin unchanged.
- R7: With bits 6 and 1 set, each tick drives `pin_out` at the next edge. The pin goes to 0 if the counter's low byte is below the duty byte and to 1 otherwise.
- R8: In PWM operation, a tick whose counter low byte is 00 copies register bits 15:8 into bits 7:0. The comparison made on that same tick already uses the copied value.
- R9: The flag stays set until `flag_clr` is raised. A set event in the same cycle as `flag_clr` leaves the flag at 1.
- R10: `irq_chan` equals the flag ANDed with mode bit 0. `irq_shared` equals the flag ANDed with `shared_en`.
- R11: A mode word of 0 keeps `pin_out` at its last value and sets no flag, whether on pin edges or on matches.
- R12: A capture on the same clock edge as a software write to the register wins, and the register takes the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | High for one cycle per counter increment |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 7 | Mode word write data |
| caplo_wr | input | 1 | Write strobe for register bits 7:0 |
| caphi_wr | input | 1 | Write strobe for register bits 15:8 |
| cap_wdata | input | 8 | Register byte write data |
| flag_clr | input | 1 | Software clear of the event flag |
| shared_en | input | 1 | Enable for the shared interrupt request |
| pin_in | input | 1 | Asynchronous capture input |
| mode_q | output | 7 | Current mode word |
| cap_q | output | 16 | Current capture/compare register |
| pin_out | output | 1 | Channel output pin |
| evt_flag | output | 1 | Sticky event flag |
| irq_chan | output | 1 | Per-channel interrupt request |
| irq_shared | output | 1 | Contribution to the shared interrupt request |

## Verification
A hardware capture and a software action can land on the same clock edge. Two such pairs are a capture with a software write to the register, and a flag set with a software flag clear. The bench counts the synchroniser latency so that the capture strobe meets a register byte write and a `flag_clr` pulse on the same edge. It then expects the counter value in the register and the flag still set. Random matches, near-misses and PWM duty reloads run against bench models of the register, the duty byte and the pin.

// File: rtl/cc_pkg.sv
// Shared types for the capture/compare channel.
// Assumes the mode word is exactly seven bits, with compare enable at the top.
package cc_pkg;
    typedef struct packed {
        logic cmp_en;    // bit 6
        logic cap_pos;   // bit 5
        logic cap_neg;   // bit 4
        logic match_en;  // bit 3
        logic toggle_en; // bit 2
        logic pwm_en;    // bit 1
        logic irq_en;    // bit 0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/cc_edge_sync.sv
// Synchronises an asynchronous pin through STAGES flops and flags the selected edges.
// Assumes the pin is low at reset. The edge strobe is combinational off the last flops.
module cc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic rise_en,
    input  logic fall_en,
    output logic edge_evt
);
    logic [STAGES:0] chain;
    logic            cur_lvl;
    logic            old_lvl;

    // Shift the pin through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin_in};
    end

    assign cur_lvl  = chain[STAGES-1];
    assign old_lvl  = chain[STAGES];

    // Select qualifying transitions.
    always_comb begin
        edge_evt = (rise_en & cur_lvl & ~old_lvl) | (fall_en & ~cur_lvl & old_lvl);
    end

    // R2: a rising event implies the pin was high STAGES edges earlier (checked for the two-flop default).
    p_edge_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && rise_en && !fall_en && edge_evt) |-> $past(pin_in, 2));
endmodule

// File: rtl/cc_compare.sv
// Equality and PWM comparison against the shared counter.
// Assumes cnt_tick is high once per counter increment. Purely combinational.
module cc_compare #(
    parameter int CW = 16
) (
    input  logic          cmp_en,
    input  logic          pwm_en,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_tick,
    input  logic [CW-1:0] cap_q,
    output logic          match_hit,
    output logic          pwm_step,
    output logic          pwm_wrap,
    output logic          pwm_level
);
    localparam int HW = CW / 2;

    logic [HW-1:0] duty_eff;

    // Full-width match, one per increment.
    always_comb match_hit = cmp_en & cnt_tick & (cnt_val == cap_q);

    // PWM: low-byte wrap, effective duty, output level.
    always_comb begin
        pwm_step  = cmp_en & pwm_en & cnt_tick;
        pwm_wrap  = pwm_step & (cnt_val[HW-1:0] == '0);
        duty_eff  = pwm_wrap ? cap_q[CW-1:HW] : cap_q[HW-1:0];
        pwm_level = (cnt_val[HW-1:0] >= duty_eff);
    end
endmodule

// File: rtl/cc_flag_irq.sv
// Sticky event flag and its two interrupt requests.
// Assumes a hardware set takes priority over a software clear in the same cycle.
module cc_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    input  logic irq_en,
    input  logic shared_en,
    output logic flag,
    output logic irq_chan,
    output logic irq_shared
);
    // Hold the flag until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    // Gate the flag onto both requests.
    always_comb begin
        irq_chan   = flag & irq_en;
        irq_shared = flag & shared_en;
    end

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_set_beats_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
endmodule

// File: rtl/cc_channel.sv
// One capture/compare channel on a shared counter: edge capture, match flag,
// toggle on match and 8-bit PWM with duty reload at low-byte wrap.
// Assumes the counter and bus decoding live outside. Register strobes are single-cycle.
module cc_channel #(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           cnt_val,
    input  logic                    cnt_tick,
    input  logic                    mode_wr,
    input  logic [cc_pkg::MODE_W-1:0] mode_wdata,
    input  logic                    caplo_wr,
    input  logic                    caphi_wr,
    input  logic [CW/2-1:0]         cap_wdata,
    input  logic                    flag_clr,
    input  logic                    shared_en,
    input  logic                    pin_in,
    output logic [cc_pkg::MODE_W-1:0] mode_q,
    output logic [CW-1:0]           cap_q,
    output logic                    pin_out,
    output logic                    evt_flag,
    output logic                    irq_chan,
    output logic                    irq_shared
);
    import cc_pkg::*;
    localparam int HW = CW / 2;

    mode_t mode_r;
    logic  cap_evt, match_hit, pwm_step, pwm_wrap, pwm_level;
    logic  flag_set;

    // Mode word register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_r <= '0;
        else if (mode_wr) mode_r <= mode_t'(mode_wdata);
    end
    assign mode_q = mode_r;

    cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .rise_en(mode_r.cap_pos), .fall_en(mode_r.cap_neg),
        .edge_evt(cap_evt)
    );

    cc_compare #(.CW(CW)) u_cmp (
        .cmp_en(mode_r.cmp_en), .pwm_en(mode_r.pwm_en),
        .cnt_val(cnt_val), .cnt_tick(cnt_tick), .cap_q(cap_q),
        .match_hit(match_hit), .pwm_step(pwm_step),
        .pwm_wrap(pwm_wrap), .pwm_level(pwm_level)
    );

    // Capture/compare register: capture first, then reload or software bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_evt) begin
            cap_q <= cnt_val;
        end else begin
            if (pwm_wrap)      cap_q[HW-1:0] <= cap_q[CW-1:HW];
            else if (caplo_wr) cap_q[HW-1:0] <= cap_wdata;
            if (caphi_wr)      cap_q[CW-1:HW] <= cap_wdata;
        end
    end

    // Output pin: PWM level, else toggle on match, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_out <= 1'b1;
        else if (pwm_step)
            pin_out <= pwm_level;
        else if (match_hit && mode_r.match_en && mode_r.toggle_en)
            pin_out <= ~pin_out;
    end

    assign flag_set = cap_evt | (match_hit & mode_r.match_en);

    cc_flag_irq u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(flag_set), .clr(flag_clr),
        .irq_en(mode_r.irq_en), .shared_en(shared_en),
        .flag(evt_flag), .irq_chan(irq_chan), .irq_shared(irq_shared)
    );

    p_capture_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cnt_val)));
    p_hso_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && mode_r.match_en && mode_r.toggle_en && !mode_r.pwm_en) |=> (pin_out != $past(pin_out)));
    p_pwm_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_step |=> (pin_out == ($past(cnt_val[HW-1:0]) >= (($past(cnt_val[HW-1:0]) == '0) ? $past(cap_q[CW-1:HW]) : $past(cap_q[HW-1:0])))));
    p_duty_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_wrap && !cap_evt) |=> (cap_q[HW-1:0] == $past(cap_q[CW-1:HW])));
    p_noop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == '0) |=> $stable(pin_out));
endmodule

// File: tb/cc_channel_tb_top.sv
module cc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic        mode_wr = 1'b0;
    logic [6:0]  mode_wdata = '0;
    logic        caplo_wr = 1'b0;
    logic        caphi_wr = 1'b0;
    logic [7:0]  cap_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        shared_en = 1'b0;
    logic        pin_in = 1'b0;
    logic [6:0]  mode_q;
    logic [15:0] cap_q;
    logic        pin_out, evt_flag, irq_chan, irq_shared;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .caplo_wr(caplo_wr),
        .caphi_wr(caphi_wr), .cap_wdata(cap_wdata), .flag_clr(flag_clr),
        .shared_en(shared_en), .pin_in(pin_in), .mode_q(mode_q), .cap_q(cap_q),
        .pin_out(pin_out), .evt_flag(evt_flag), .irq_chan(irq_chan),
        .irq_shared(irq_shared)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [6:0] m);
        mode_wr = 1'b1; mode_wdata = m; step(); mode_wr = 1'b0;
    endtask

    task automatic wr_cap(input logic [15:0] v);
        caplo_wr = 1'b1; cap_wdata = v[7:0]; step(); caplo_wr = 1'b0;
        caphi_wr = 1'b1; cap_wdata = v[15:8]; step(); caphi_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    task automatic tick_at(input logic [15:0] v);
        cnt_val = v; cnt_tick = 1'b1; step(); cnt_tick = 1'b0;
    endtask

    function automatic logic pwm_exp(input logic [7:0] lo, input logic [7:0] duty);
        return (lo >= duty);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] c, v;
        logic [7:0]  hi_m, duty_m, lo;
        logic        exp_pin;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", mode_q, 0); chk("R1 cap", cap_q, 0);
        chk("R1 pin", pin_out, 1); chk("R1 flag", evt_flag, 0);
        chk("R1 irq", {irq_chan, irq_shared}, 0);
        wr_mode(7'h55);
        chk("R1 readback", mode_q, 7'h55);
        wr_mode(7'h00);

        // R2 rising capture (mode: bit5 + bit0)
        wr_mode(7'h21);
        cnt_val = 16'h1234;
        pin_in = 1'b1; step(); step();
        chk("R2 not yet", cap_q, 0);
        step();
        chk("R2 cap", cap_q, 16'h1234); chk("R2 flag", evt_flag, 1);
        shared_en = 1'b1; step();
        chk("R10 chan", irq_chan, 1); chk("R10 shared", irq_shared, 1);
        shared_en = 1'b0; step();
        chk("R10 shared off", irq_shared, 0);

        // R3 falling only
        pin_in = 1'b0; repeat (4) step();
        wr_mode(7'h10); clr_flag();
        chk("R10 chan ie off", irq_chan, 0);
        cnt_val = 16'hBEEF;
        pin_in = 1'b1; repeat (4) step();
        chk("R3 rise ignored cap", cap_q, 16'h1234); chk("R3 rise ignored flag", evt_flag, 0);
        pin_in = 1'b0; repeat (3) step();
        chk("R3 fall cap", cap_q, 16'hBEEF); chk("R3 fall flag", evt_flag, 1);

        // R4 both edges
        wr_mode(7'h30); clr_flag();
        cnt_val = 16'h0F0F; pin_in = 1'b1; repeat (4) step();
        chk("R4 rise", cap_q, 16'h0F0F);
        cnt_val = 16'hA5A5; pin_in = 1'b0; repeat (4) step();
        chk("R4 fall", cap_q, 16'hA5A5);

        // R12 + R9 collision: capture, byte write and clear on one edge
        wr_mode(7'h20); clr_flag();
        cnt_val = 16'h7777; pin_in = 1'b1; step(); step();
        caplo_wr = 1'b1; cap_wdata = 8'h11; flag_clr = 1'b1; step();
        caplo_wr = 1'b0; flag_clr = 1'b0;
        chk("R12 capture wins", cap_q, 16'h7777);
        chk("R9 set beats clear", evt_flag, 1);
        step(); chk("R9 sticky", evt_flag, 1);
        clr_flag(); chk("R9 cleared", evt_flag, 0);
        pin_in = 1'b0; repeat (4) step();

        // R5 software timer
        wr_mode(7'h48); clr_flag();
        wr_cap(16'h0102);
        cnt_val = 16'h0102; step();
        chk("R5 no tick", evt_flag, 0);
        tick_at(16'h0102);
        chk("R5 match", evt_flag, 1);
        for (int i = 0; i < 16; i++) begin
            c = 16'($urandom);
            wr_cap(c); clr_flag();
            v = ($urandom % 2 == 0) ? c : (c ^ (16'h1 << ($urandom % 16)));
            tick_at(v);
            chk("R5 random", evt_flag, (v == c));
        end

        // R6 toggle on match
        wr_mode(7'h4C); wr_cap(16'h0010);
        exp_pin = pin_out;
        tick_at(16'h0010); exp_pin = ~exp_pin; chk("R6 toggle", pin_out, exp_pin);
        tick_at(16'h0011); chk("R6 miss holds", pin_out, exp_pin);
        tick_at(16'h0010); exp_pin = ~exp_pin; chk("R6 toggle back", pin_out, exp_pin);

        // R11 no-op mode
        wr_mode(7'h00); clr_flag();
        exp_pin = pin_out;
        tick_at(16'h0010);
        pin_in = 1'b1; repeat (4) step();
        pin_in = 1'b0; repeat (4) step();
        chk("R11 pin held", pin_out, exp_pin); chk("R11 no flag", evt_flag, 0);
        chk("R11 no capture", cap_q, 16'h0010);

        // R7/R8 PWM
        wr_mode(7'h42);
        wr_cap(16'h8040); hi_m = 8'h80; duty_m = 8'h40;
        tick_at(16'h003F); chk("R7 below", pin_out, 0);
        tick_at(16'h0040); chk("R7 equal", pin_out, 1);
        tick_at(16'h0000); duty_m = hi_m;
        chk("R8 wrap level", pin_out, 0); chk("R8 reload", cap_q[7:0], 8'h80);
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 4 == 0) begin
                hi_m = 8'($urandom);
                caphi_wr = 1'b1; cap_wdata = hi_m; step(); caphi_wr = 1'b0;
            end
            lo = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            if (lo == 8'h00) duty_m = hi_m;
            tick_at({8'($urandom), lo});
            chk("R7 random level", pin_out, pwm_exp(lo, duty_m));
            chk("R8 duty byte", cap_q[7:0], duty_m);
        end
        chk("R7 no flag in pwm", evt_flag, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule